// File: doc/BRIEF.md
# Bit-Serial Sixteen-Channel Corner-Turning Router

This block moves data between sixteen source words and sixteen destination words one bit at a time. Each source word sits in an input shift register that presents its most significant bit. Every transfer cycle takes a source address and a destination address. A pair of eight-way selectors puts the addressed source bit on a single shared bus bit, and a disable term derived from the top address bit keeps only one of the two selectors driving. That bus bit then reaches the destination side through the inhibit input of a one-hot decoder. The bus bit is inverted before it enters the inhibit input, so the addressed destination register shifts in the same value the source presented.

Sixteen accepted transfers form one frame. At the end of each frame every input register shifts by one position, so it presents its next bit, and a frame strobe pulses. Because the user supplies the source/destination sequence freely, bit positions can be re-sliced across words. Eight frames of the right sequence transpose each bank of eight words into another. Identity copies and broadcasts are just other sequences. A parallel load fills the input registers and restarts the frame count.

Top module: `bit_router`

## Requirements
- R1: A synchronous active-high reset clears all sixteen output words, all input registers and the transfer counter, and drives `frame_strobe` low from the next cycle.
- R2: On a clock edge with `xfer_valid`=1 and `load_en`=0, output word `dst_addr` shifts left by one and its bit 0 takes bit 7 (the MSB) of input register `src_addr`. `src_addr` bit 3 picks the group (0: registers 0..7, 1: registers 8..15) and bits 2:0 pick the register within the group.
- R3: In a transfer cycle every output word other than `dst_addr` keeps its value. In a cycle with no accepted transfer, all output words keep their value.
- R4: On the edge that accepts the 16th transfer since the last reset, load or frame end, every input register shifts left by one with a zero entering bit 0. `frame_strobe` is high during exactly the following cycle and low otherwise.
- R5: With `load_en`=1, input register i is loaded from `load_data[8*i +: 8]` and the transfer counter returns to 0. A transfer requested in the same cycle is ignored: no output word changes and it is not counted.
- R6: Over eight frames in which frame f sends sources 0..7 to destination f and sources 8..15 to destination 8+f, bit 7-j of output word f equals bit 7-f of input word j, and bit 7-j of output word 8+f equals bit 7-f of input word 8+j. Output word i is read at `out_words[8*i +: 8]`.
- R7: A destination may receive any source sequence, including the same source bit broadcast to several destinations within one frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Parallel load of all input registers |
| load_data | input | 128 | Sixteen 8-bit source words, word i at bits 8i+7..8i |
| xfer_valid | input | 1 | Request one bit transfer this cycle |
| src_addr | input | 4 | Source register address (bit 3 = group) |
| dst_addr | input | 4 | Destination register address |
| out_words | output | 128 | Sixteen 8-bit destination words, word i at bits 8i+7..8i |
| frame_strobe | output | 1 | One-cycle pulse after the 16th transfer of a frame |

## Verification
The hardest state to reach is the frame boundary combined with other events: a 16th transfer that must use the old MSB while the input registers shift on the same edge, and a load that lands mid-frame together with a transfer request that has to be discarded without being counted. The bench drives a full eight-frame transpose and an identity sequence so that every bit position of every source crosses the boundary. It then issues a load with a colliding transfer after a partial frame and counts exactly sixteen further transfers to find the next strobe. A broadcast frame checks that the inverted inhibit path carries both 0 and 1 correctly to several destinations.

// File: rtl/bit_router_pkg.sv
package bit_router_pkg;
  localparam int DEF_CH = 16;
  localparam int DEF_W  = 8;

  function automatic int addr_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/src_sel8.sv
module src_sel8 #(
  parameter int GRP   = 8,
  parameter int SEL_W = 3
) (
  input  logic [GRP-1:0]   msbs,
  input  logic [SEL_W-1:0] sel,
  input  logic             off,
  output logic             bit_o
);
  always_comb begin
    bit_o = 1'b0;
    if (!off) bit_o = msbs[sel];
  end
endmodule

// File: rtl/hot_decoder.sv
module hot_decoder #(
  parameter int N      = 16,
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              inhibit,
  output logic [N-1:0]      hot,
  output logic [N-1:0]      line
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      hot[i]  = (addr == ADDR_W'(i));
      line[i] = hot[i] && !inhibit;
    end
  end
endmodule

// File: rtl/bit_router.sv
module bit_router
  import bit_router_pkg::*;
#(
  parameter int NUM_CH = DEF_CH,
  parameter int WORD_W = DEF_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load_en,
  input  logic [NUM_CH*WORD_W-1:0] load_data,
  input  logic                     xfer_valid,
  input  logic [addr_bits(NUM_CH)-1:0] src_addr,
  input  logic [addr_bits(NUM_CH)-1:0] dst_addr,
  output logic [NUM_CH*WORD_W-1:0] out_words,
  output logic                     frame_strobe
);
  localparam int ADDR_W = addr_bits(NUM_CH);
  localparam int GRP    = NUM_CH / 2;
  localparam int SEL_W  = ADDR_W - 1;

  logic [NUM_CH*WORD_W-1:0] in_flat;
  logic [NUM_CH-1:0]        msb_vec;
  logic [1:0]               grp_bit;
  logic                     bus_bit;
  logic [NUM_CH-1:0]        dec_hot;
  logic [NUM_CH-1:0]        dec_line;
  logic [ADDR_W-1:0]        xfer_cnt;
  logic                     xfer_ok;
  logic                     frame_end;

  assign xfer_ok   = xfer_valid && !load_en;
  assign frame_end = xfer_ok && (xfer_cnt == ADDR_W'(NUM_CH - 1));

  // input shift registers, MSB presented to the selectors
  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_in
      always_ff @(posedge clk) begin
        if (rst)
          in_flat[gi*WORD_W +: WORD_W] <= '0;
        else if (load_en)
          in_flat[gi*WORD_W +: WORD_W] <= load_data[gi*WORD_W +: WORD_W];
        else if (frame_end)
          in_flat[gi*WORD_W +: WORD_W] <= {in_flat[gi*WORD_W +: WORD_W-1], 1'b0};
      end
      assign msb_vec[gi] = in_flat[gi*WORD_W + WORD_W - 1];
    end

    // two eight-way selectors sharing one bus bit; the unused one is disabled
    for (gi = 0; gi < 2; gi++) begin : g_sel
      src_sel8 #(.GRP(GRP), .SEL_W(SEL_W)) u_sel (
        .msbs (msb_vec[gi*GRP +: GRP]),
        .sel  (src_addr[SEL_W-1:0]),
        .off  (src_addr[ADDR_W-1] != 1'(gi)),
        .bit_o(grp_bit[gi])
      );
    end
  endgenerate

  assign bus_bit = grp_bit[0] | grp_bit[1];

  // bus bit inverted into the inhibit input: selected line equals the bus bit
  hot_decoder #(.N(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .addr   (dst_addr),
    .inhibit(~bus_bit),
    .hot    (dec_hot),
    .line   (dec_line)
  );

  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_out
      always_ff @(posedge clk) begin
        if (rst)
          out_words[gi*WORD_W +: WORD_W] <= '0;
        else if (xfer_ok && dec_hot[gi])
          out_words[gi*WORD_W +: WORD_W] <= {out_words[gi*WORD_W +: WORD_W-1], dec_line[gi]};
      end
    end
  endgenerate

  // transfer sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      xfer_cnt     <= '0;
      frame_strobe <= 1'b0;
    end else begin
      frame_strobe <= frame_end;
      if (load_en)
        xfer_cnt <= '0;
      else if (xfer_ok)
        xfer_cnt <= (xfer_cnt == ADDR_W'(NUM_CH - 1)) ? '0 : xfer_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bit_router_chk.sv
module bit_router_chk #(
  parameter int NUM_CH = 16,
  parameter int WORD_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     load_en,
  input logic                     xfer_valid,
  input logic [ADDR_W-1:0]        src_addr,
  input logic [ADDR_W-1:0]        dst_addr,
  input logic [NUM_CH*WORD_W-1:0] in_flat,
  input logic [NUM_CH*WORD_W-1:0] out_words,
  input logic                     frame_strobe,
  input logic [NUM_CH-1:0]        dec_line
);
  logic [ADDR_W-1:0] seen;
  logic              acc;
  logic              src_msb;

  assign acc     = xfer_valid && !load_en;
  assign src_msb = in_flat[32'(src_addr)*WORD_W + WORD_W - 1];

  always_ff @(posedge clk) begin
    if (rst || load_en) seen <= '0;
    else if (acc) seen <= seen + 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (out_words == '0 && in_flat == '0 && !frame_strobe));

  assert_dst_bit_R2: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_words[32'($past(dst_addr))*WORD_W] == $past(src_msb));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable(out_words));

  assert_line_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dec_line));

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_hold
      assert_other_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (acc && dst_addr != ADDR_W'(gi)) |=> $stable(out_words[gi*WORD_W +: WORD_W]));
    end
  endgenerate

  assert_strobe_on_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && seen == ADDR_W'(NUM_CH - 1)) |=> frame_strobe);

  assert_strobe_off_R4: assert property (@(posedge clk) disable iff (rst)
    !(acc && seen == ADDR_W'(NUM_CH - 1)) |=> !frame_strobe);

  assert_load_R5: assert property (@(posedge clk) disable iff (rst)
    load_en |=> $stable(out_words));
endmodule

bind bit_router bit_router_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .load_en(load_en), .xfer_valid(xfer_valid),
  .src_addr(src_addr), .dst_addr(dst_addr), .in_flat(in_flat),
  .out_words(out_words), .frame_strobe(frame_strobe), .dec_line(dec_line)
);

// File: tb/sim_bit_router.sv
`timescale 1ns/1ps
module sim_bit_router;
  localparam int N = 16;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst;
  logic           load_en;
  logic [N*W-1:0] load_data;
  logic           xfer_valid;
  logic [3:0]     src_addr;
  logic [3:0]     dst_addr;
  logic [N*W-1:0] out_words;
  logic           frame_strobe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [W-1:0] m_in  [N];
  logic [W-1:0] m_out [N];
  logic [W-1:0] orig  [N];
  int           m_cnt;

  bit_router u0 (
    .clk(clk), .rst(rst), .load_en(load_en), .load_data(load_data),
    .xfer_valid(xfer_valid), .src_addr(src_addr), .dst_addr(dst_addr),
    .out_words(out_words), .frame_strobe(frame_strobe)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] model_flat();
    logic [N*W-1:0] f;
    for (int i = 0; i < N; i++) f[i*W +: W] = m_out[i];
    return f;
  endfunction

  task automatic idle();
    @(negedge clk);
    load_en = 0; xfer_valid = 0; rst = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; load_en = 0; xfer_valid = 0;
    @(negedge clk);
    rst = 0;
    for (int i = 0; i < N; i++) begin m_in[i] = '0; m_out[i] = '0; end
    m_cnt = 0;
  endtask

  task automatic do_load(input logic [W-1:0] seed);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      orig[i] = W'(seed * (i + 3) + i * 37 + 8'h5A);
      load_data[i*W +: W] = orig[i];
      m_in[i] = orig[i];
    end
    load_en = 1; xfer_valid = 0;
    m_cnt = 0;
    @(negedge clk);
    load_en = 0;
  endtask

  // one transfer; checks frame_strobe after the edge
  task automatic do_xfer(input int s, input int d);
    logic exp_strobe;
    @(negedge clk);
    xfer_valid = 1; src_addr = 4'(s); dst_addr = 4'(d); load_en = 0;
    m_out[d] = {m_out[d][W-2:0], m_in[s][W-1]};
    m_cnt++;
    exp_strobe = (m_cnt == N);
    if (m_cnt == N) begin
      m_cnt = 0;
      for (int i = 0; i < N; i++) m_in[i] = {m_in[i][W-2:0], 1'b0};
    end
    @(negedge clk);
    xfer_valid = 0;
    checks++;
    if (frame_strobe !== exp_strobe) begin
      errors++;
      $display("FAIL R4: frame_strobe actual %b expected %b", frame_strobe, exp_strobe);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 outputs clear", out_words, '0);
    check("R1 strobe low", {127'd0, frame_strobe}, '0);
  endtask

  task automatic t_identity();
    do_load(8'h13);
    for (int f = 0; f < W; f++)
      for (int c = 0; c < N; c++) do_xfer(c, c);
    check("R2 identity vs model", out_words, model_flat());
    for (int i = 0; i < N; i++) begin
      checks++;
      if (out_words[i*W +: W] !== orig[i]) begin
        errors++;
        $display("FAIL R2: word %0d actual %h expected %h", i, out_words[i*W +: W], orig[i]);
      end
    end
  endtask

  task automatic t_transpose();
    logic [W-1:0] e;
    do_reset();
    do_load(8'hC7);
    for (int f = 0; f < W; f++) begin
      for (int j = 0; j < 8; j++) do_xfer(j, f);
      for (int j = 0; j < 8; j++) do_xfer(8 + j, 8 + f);
    end
    for (int f = 0; f < 8; f++) begin
      for (int j = 0; j < 8; j++) e[7-j] = orig[j][7-f];
      check("R6 transpose low bank", {120'd0, out_words[f*W +: W]}, {120'd0, e});
      for (int j = 0; j < 8; j++) e[7-j] = orig[8+j][7-f];
      check("R6 transpose high bank", {120'd0, out_words[(8+f)*W +: W]}, {120'd0, e});
    end
  endtask

  task automatic t_hold();
    logic [N*W-1:0] snap;
    snap = out_words;
    for (int k = 0; k < 5; k++) idle();
    @(negedge clk);
    check("R3 idle hold", out_words, snap);
    do_xfer(3, 9);
    snap[9*W +: W] = m_out[9];
    check("R3 others hold on transfer", out_words, snap);
  endtask

  task automatic t_broadcast();
    do_reset();
    do_load(8'h21);
    for (int c = 0; c < N; c++) do_xfer(c[0] ? 12 : 5, c);
    check("R7 broadcast frame", out_words, model_flat());
    for (int c = 0; c < N; c++) do_xfer(15 - c, (c * 7) % N);
    check("R7 scrambled frame", out_words, model_flat());
  endtask

  task automatic t_load_collide();
    logic [N*W-1:0] snap;
    for (int c = 0; c < 5; c++) do_xfer(c, c);
    snap = out_words;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      orig[i] = W'(8'hF0 ^ (i * 11));
      load_data[i*W +: W] = orig[i];
      m_in[i] = orig[i];
    end
    load_en = 1; xfer_valid = 1; src_addr = 4'd2; dst_addr = 4'd2;
    m_cnt = 0;
    @(negedge clk);
    load_en = 0; xfer_valid = 0;
    check("R5 colliding transfer ignored", out_words, snap);
    for (int c = 0; c < N; c++) do_xfer(N - 1 - c, c);
    check("R5 new data routed after load", out_words, model_flat());
  endtask

  task automatic t_reset_mid();
    for (int c = 0; c < 3; c++) do_xfer(c, 0);
    do_reset();
    check("R1 mid-run reset clears", out_words, '0);
    for (int c = 0; c < N; c++) do_xfer(c, c);
    check("R1 input registers cleared", out_words, '0);
  endtask

  initial begin
    rst = 1; load_en = 0; xfer_valid = 0; src_addr = 0; dst_addr = 0; load_data = '0;
    m_cnt = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_identity();
    t_hold();
    t_transpose();
    t_broadcast();
    t_load_collide();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule